// File: doc/BRIEF.md
# Memory Decoder Control Register File

This block is the register file for a group of host-managed memory decoders. A simple register bus reaches it, and the bus carries a strobe, a write enable, a byte address, 32-bit write data and a flag for 64-bit width. The file holds one constant capability word, one global control word and a parameterised number of decoder sets. Each decoder set has base, size, control and target-list registers. Software programs a set's address window and interleave settings, and then requests a commit through that set's control register. The control register reports the commit state back in its status bits.

Each write is merged with the stored value under a fixed mask for its register. Bits outside the mask keep their contents, so read-only fields cannot be altered. A write to a control register also settles the commit handshake in the same cycle. The committed status bit follows the commit request, and the error status bit is cleared. Reads are combinational from the address and return zero for anything that is not a mapped, aligned 32-bit register.

Top module: `mdec_regfile`

## Requirements
- R1: After reset the capability word at byte 0x00 reads 0x00000312 and every other register reads zero. The capability word uses these fields: bits 3:0 hold the decoder-count code (4 sets encode as 2), bits 7:4 hold a target count of 1, bit 8 flags 256-byte interleave and bit 9 flags 4 KiB interleave.
- R2: The capability word is read-only, and a write to byte 0x00 leaves it at 0x00000312.
- R3: Base-low (set offset 0x0) and size-low (set offset 0x8) store only bits 31:28 of written data. The remaining bits keep their stored value, which is zero.
- R4: Base-high (0x4), size-high (0xC) and target-list-high (0x18) store all 32 written bits.
- R5: A write to a set's control register (offset 0x10) keeps the written bits under mask 0x000013FF. If written bit 9 (commit) is 1, the stored bit 10 (committed) becomes 1 and bit 11 (error) becomes 0.
- R6: A control write with bit 9 clear stores committed (bit 10) as 0 and error (bit 11) as 0.
- R7: Target-list-low (offset 0x14) stores written bits under mask 0xF0000000 in endpoint configuration (the default), or under mask 0xFFFFFFFF otherwise.
- R8: An access with the 64-bit flag set reads zero and writes nothing.
- R9: An unmapped or misaligned address reads zero, and a write to it changes no register.
- R10: The global control register at byte 0x04 stores only bits 1:0 of written data.
- R11: Decoder set n starts at byte 0x10 + 0x20·n. A write to one set does not change any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size64 | input | 1 | Access is 64 bits wide (not acted on) |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when idle |

## Verification
A wrong mask or a wrong address decode shows on the very next read of the affected register. It appears either as a bit that should have stuck at zero, or as a neighbouring register or set that changed when it should not have. A faulty commit handshake shows in the control read one cycle after the write: bit 10 fails to track the commit request, or bit 11 is left set. Writes that should be dropped (64-bit, misaligned, unmapped, capability) are followed by reads of the registers they might have hit, so a leak is seen at once.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    localparam int DATA_W        = 32;
    localparam int SET_BASE_OFF  = 'h10;
    localparam int SET_STRIDE    = 'h20;
    localparam int CAP_OFF       = 'h00;
    localparam int GCTL_OFF      = 'h04;

    localparam int CTL_COMMIT    = 9;
    localparam int CTL_COMMITTED = 10;
    localparam int CTL_ERROR     = 11;

    localparam logic [DATA_W-1:0] GCTL_MASK = 32'h0000_0003;

    // Register kinds inside one decoder set; value = offset / 4
    typedef enum logic [2:0] {
        RK_BASE_LO = 3'd0,
        RK_BASE_HI = 3'd1,
        RK_SIZE_LO = 3'd2,
        RK_SIZE_HI = 3'd3,
        RK_CTRL    = 3'd4,
        RK_TGT_LO  = 3'd5,
        RK_TGT_HI  = 3'd6,
        RK_NONE    = 3'd7
    } reg_kind_e;

    typedef struct packed {
        logic      hit_cap;
        logic      hit_gctl;
        logic      hit_set;
        logic [3:0] set_idx;
        reg_kind_e kind;
    } addr_hit_t;

    function automatic logic [3:0] dec_count_code(int n);
        case (n)
            1:       return 4'h0;
            2:       return 4'h1;
            4:       return 4'h2;
            6:       return 4'h3;
            8:       return 4'h4;
            10:      return 4'h5;
            default: return 4'h0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] cap_word(int n);
        logic [DATA_W-1:0] w;
        w       = '0;
        w[3:0]  = dec_count_code(n);
        w[7:4]  = 4'd1;
        w[8]    = 1'b1;
        w[9]    = 1'b1;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] set_reg_mask(reg_kind_e k, logic endpoint);
        case (k)
            RK_BASE_LO, RK_SIZE_LO: return 32'hF000_0000;
            RK_BASE_HI, RK_SIZE_HI,
            RK_TGT_HI:              return 32'hFFFF_FFFF;
            RK_CTRL:                return 32'h0000_13FF;
            RK_TGT_LO:              return endpoint ? 32'hF000_0000 : 32'hFFFF_FFFF;
            default:                return 32'h0000_0000;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] masked_merge(logic [DATA_W-1:0] old_v,
                                                       logic [DATA_W-1:0] new_v,
                                                       logic [DATA_W-1:0] mask);
        return (new_v & mask) | (old_v & ~mask);
    endfunction

endpackage

// File: rtl/mdec_addr_dec.sv
module mdec_addr_dec
    import mdec_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size64,
    output addr_hit_t         hit
);
    localparam int SET_END = SET_BASE_OFF + NUM_SETS * SET_STRIDE;

    logic [ADDR_W-1:0] rel;
    logic [4:0]        off;

    assign rel = addr - ADDR_W'(SET_BASE_OFF);
    assign off = rel[4:0];

    always_comb begin
        hit         = '0;
        hit.kind    = RK_NONE;
        if (!size64 && addr[1:0] == 2'b00) begin
            if (int'(addr) == CAP_OFF) begin
                hit.hit_cap = 1'b1;
            end else if (int'(addr) == GCTL_OFF) begin
                hit.hit_gctl = 1'b1;
            end else if (int'(addr) >= SET_BASE_OFF && int'(addr) < SET_END) begin
                hit.set_idx = 4'(rel >> 5);
                hit.kind    = reg_kind_e'(off[4:2]);
                hit.hit_set = (off[4:2] != 3'd7);
            end
        end
    end
endmodule

// File: rtl/mdec_set.sv
module mdec_set
    import mdec_pkg::*;
#(
    parameter bit ENDPOINT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs_q [7];
    logic [DATA_W-1:0] merged;

    always_comb begin
        merged = '0;
        if (kind != RK_NONE) begin
            merged = masked_merge(regs_q[kind], wdata, set_reg_mask(kind, ENDPOINT));
            if (kind == RK_CTRL) begin
                merged[CTL_COMMITTED] = merged[CTL_COMMIT];
                merged[CTL_ERROR]     = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 7; i++) regs_q[i] <= '0;
        end else if (wr_en && kind != RK_NONE) begin
            regs_q[kind] <= merged;
        end
    end

    assign rdata = (kind == RK_NONE) ? '0 : regs_q[kind];

    // R5
    commit_track_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_CTRL) |=> regs_q[RK_CTRL][CTL_COMMITTED] == $past(wdata[CTL_COMMIT]));

    // R6
    error_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind == RK_CTRL) |=> !regs_q[RK_CTRL][CTL_ERROR]);

    // R11
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && kind == RK_BASE_LO) |=> $stable(regs_q[RK_BASE_LO]));
endmodule

// File: rtl/mdec_regfile.sv
module mdec_regfile
    import mdec_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_SETS = 4,
    parameter bit ENDPOINT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic              bus_size64,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam int SIDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
    localparam logic [DATA_W-1:0] CAP_WORD = cap_word(NUM_SETS);

    addr_hit_t         hit;
    logic              wr;
    logic [DATA_W-1:0] gctl_q;
    logic [DATA_W-1:0] set_rd [NUM_SETS];

    mdec_addr_dec #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS)) dec_i (
        .addr   (bus_addr),
        .size64 (bus_size64),
        .hit    (hit)
    );

    assign wr = bus_valid && bus_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            gctl_q <= '0;
        end else if (wr && hit.hit_gctl) begin
            gctl_q <= masked_merge(gctl_q, bus_wdata, GCTL_MASK);
        end
    end

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        mdec_set #(.ENDPOINT(ENDPOINT)) set_i (
            .clk   (clk),
            .rst   (rst),
            .wr_en (wr && hit.hit_set && hit.set_idx == 4'(g)),
            .kind  (hit.kind),
            .wdata (bus_wdata),
            .rdata (set_rd[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_we) begin
            if (hit.hit_cap)       bus_rdata = CAP_WORD;
            else if (hit.hit_gctl) bus_rdata = gctl_q;
            else if (hit.hit_set)  bus_rdata = set_rd[hit.set_idx[SIDX_W-1:0]];
        end
    end

    // R8
    wide_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_we && bus_size64) |=> $stable(gctl_q));

    // R10
    gctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr && hit.hit_gctl) |=> $stable(gctl_q));

    // R9
    misaligned_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> !(hit.hit_cap || hit.hit_gctl || hit.hit_set));
endmodule

// File: tb/mdec_regfile_tb_top.sv
module mdec_regfile_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_size64 = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdec_regfile dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_size64(bus_size64), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit wide = 1'b0);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b1; bus_size64 = wide; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0; bus_size64 = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req,
                          input bit wide = 1'b0);
        @(negedge clk);
        bus_valid = 1'b1; bus_we = 1'b0; bus_size64 = wide; bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h", req, a, bus_rdata, exp);
        end
        bus_valid = 1'b0; bus_size64 = 1'b0;
    endtask

    task automatic t_reset_r1();
        rd_chk(8'h00, 32'h0000_0312, "R1");
        rd_chk(8'h04, 32'h0, "R1");
        for (int s = 0; s < 4; s++)
            for (int o = 0; o < 7; o++)
                rd_chk(8'(8'h10 + s*32 + o*4), 32'h0, "R1");
    endtask

    task automatic t_cap_r2();
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk(8'h00, 32'h0000_0312, "R2");
    endtask

    task automatic t_gctl_r10();
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk(8'h04, 32'h0000_0003, "R10");
        wr(8'h04, 32'h0000_0001);
        rd_chk(8'h04, 32'h0000_0001, "R10");
    endtask

    task automatic t_lo_hi_r3_r4();
        wr(8'h10, 32'h1234_5678);
        rd_chk(8'h10, 32'h1000_0000, "R3");
        wr(8'h18, 32'hFFFF_FFFF);
        rd_chk(8'h18, 32'hF000_0000, "R3");
        wr(8'h14, 32'hDEAD_BEEF);
        rd_chk(8'h14, 32'hDEAD_BEEF, "R4");
        wr(8'h1C, 32'hFFFF_FFFF);
        rd_chk(8'h1C, 32'hFFFF_FFFF, "R4");
        wr(8'h28, 32'h0F0F_1234);
        rd_chk(8'h28, 32'h0F0F_1234, "R4");
    endtask

    task automatic t_commit_r5();
        wr(8'h40, 32'hFFFF_FFFF);
        rd_chk(8'h40, 32'h0000_17FF, "R5");
    endtask

    task automatic t_uncommit_r6();
        wr(8'h40, 32'h0000_10A5);
        rd_chk(8'h40, 32'h0000_10A5, "R6");
        wr(8'h40, 32'h0000_0200);
        rd_chk(8'h40, 32'h0000_0600, "R5");
        wr(8'h40, 32'h0000_0C00);
        rd_chk(8'h40, 32'h0000_0000, "R6");
    endtask

    task automatic t_target_r7();
        wr(8'h64, 32'hFFFF_FFFF);
        rd_chk(8'h64, 32'hF000_0000, "R7");
        wr(8'h68, 32'hA5A5_5A5A);
        rd_chk(8'h68, 32'hA5A5_5A5A, "R7");
    endtask

    task automatic t_wide_r8();
        wr(8'h74, 32'hAAAA_AAAA, 1'b1);
        rd_chk(8'h74, 32'h0, "R8");
        wr(8'h04, 32'h0000_0002, 1'b1);
        rd_chk(8'h04, 32'h0, "R8", 1'b1);
        rd_chk(8'h04, 32'h0000_0001, "R8");
    endtask

    task automatic t_unmapped_r9();
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h11, 32'h0000_0000);
        wr(8'hF0, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'h0, "R9");
        rd_chk(8'h2C, 32'h0, "R9");
        rd_chk(8'hF0, 32'h0, "R9");
        rd_chk(8'h11, 32'h0, "R9");
        rd_chk(8'h10, 32'h1000_0000, "R9");
        rd_chk(8'h30, 32'h0, "R9");
        rd_chk(8'h04, 32'h0000_0001, "R9");
    endtask

    task automatic t_indep_r11();
        wr(8'h7C, 32'h55AA_55AA);
        rd_chk(8'h7C, 32'h55AA_55AA, "R11");
        rd_chk(8'h3C, 32'h0, "R11");
        rd_chk(8'h5C, 32'h0, "R11");
        rd_chk(8'h1C, 32'hFFFF_FFFF, "R11");
        rd_chk(8'h60, 32'h0, "R11");
        rd_chk(8'h20, 32'h0, "R11");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_r1();
        t_cap_r2();
        t_gctl_r10();
        t_lo_hi_r3_r4();
        t_commit_r5();
        t_uncommit_r6();
        t_target_r7();
        t_wide_r8();
        t_unmapped_r9();
        t_indep_r11();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule